// File: doc/BRIEF.md
# Monitor Channel Byte Handshake Controller

This block runs the byte-level handshake of a framed serial monitor channel in both directions at once. Once per frame the serial port hands it the received monitor byte plus the two remote handshake bits. In the same frame it returns the byte to send and its own two handshake bits. Both handshake bits are active low. The sender bit (E) marks the bytes of an outgoing message. The receiver bit (A) acknowledges the bytes of an incoming message.

On the receive side, a byte counts as valid only once it has arrived unchanged in two consecutive frames. The block then presents it to the client with a one-cycle strobe and acknowledges it on A. Copies that differ lead to an abort request. The end of an incoming message is reported with a one-cycle pulse.

On the transmit side, the block reads a message of up to `MSG_MAX` bytes from a client buffer through an index/data pair. It places each byte, waits for the acknowledge before moving on, and marks the end of the message. After an abort from the far end it sends the whole message again. It gives up after `RETRY_LIM` frames without an acknowledge. The block does not decode message contents.

Top module: `mon_handshake`

## Requirements
- R1: After reset, out_e_n and out_a_n are 1 (inactive), out_byte is 0, and rx_valid, rx_eom, tx_done and tx_fail are 0.
- R2: All outputs change only at a clock edge where frame_stb is 1, with one exception: tx_rd_idx follows internal state, and the one-cycle pulses clear on the next edge.
- R3: With A idle, a byte received with in_e_n=0 in two consecutive frames, both copies equal, gives rx_valid with rx_data equal to that byte one frame after the second copy arrives. In that same update out_a_n goes to 0. out_a_n stays 0 while in_e_n stays 0.
- R4: After an acknowledged byte, suppose in_e_n=1 for one frame carrying a new byte and the next frame has in_e_n=0 with the same byte. Then out_a_n goes to 1 for one frame and returns to 0, with rx_valid carrying the new byte.
- R5: A following byte whose second copy differs from its flagged copy gives no rx_valid. out_a_n then stays 1 until in_e_n returns to 1, even if the remote sends matching copies in the meantime.
- R6: For the first byte of a message, a mismatch replaces the candidate byte and the comparison continues. After RETRY_LIM (8) mismatching frames the receiver aborts, and nothing is accepted until in_e_n returns to 1. With RETRY_LIM-1 mismatches, a later match is still accepted.
- R7: After an acknowledged byte, in_e_n=1 in two consecutive frames produces a one-cycle rx_eom pulse, with out_a_n at 1.
- R8: tx_start with 1 <= tx_len <= MSG_MAX arms a message. At each frame where in_a_n was 0, out_e_n stays 1. At the first frame where in_a_n was 1, out_e_n goes to 0 with out_byte equal to buffer entry 0.
- R9: A byte counts as acknowledged once in_a_n has been seen at 1 and then at 0. Until then it is held. The next byte is then placed with out_e_n=1 for exactly one frame, followed by out_e_n=0. After the last byte, out_e_n stays 1, and tx_done pulses one frame later.
- R10: While a following byte (index above 0) waits, in_a_n at 1 in two consecutive frames is an abort. out_e_n goes to 1, and the message restarts from entry 0 at the next frame where in_a_n is 1.
- R11: After RETRY_LIM (8) frames in a row in which a placed byte gets no acknowledge, tx_fail pulses, out_e_n returns to 1, and the transmitter goes idle.
- R12: tx_start is ignored while a message is in progress, and also when tx_len is 0 or greater than MSG_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per frame from the serial port |
| in_byte | input | 8 | Received monitor byte of the current frame |
| in_e_n | input | 1 | Remote sender bit, active low |
| in_a_n | input | 1 | Remote receiver bit, active low |
| out_byte | output | 8 | Monitor byte to send next frame |
| out_e_n | output | 1 | Local sender bit, active low |
| out_a_n | output | 1 | Local receiver bit, active low |
| rx_data | output | 8 | Last validated received byte |
| rx_valid | output | 1 | One-cycle strobe: rx_data is new |
| rx_eom | output | 1 | One-cycle pulse: incoming message ended |
| tx_start | input | 1 | Request to send a message |
| tx_len | input | 5 | Message length in bytes |
| tx_rd_idx | output | 4 | Buffer index of the next byte to send |
| tx_rd_data | input | 8 | Buffer byte at tx_rd_idx, combinational |
| tx_done | output | 1 | One-cycle pulse: message completed |
| tx_fail | output | 1 | One-cycle pulse: gave up after retry limit |

## Verification
The assertions assume that frame_stb is a single-cycle pulse followed by at least one idle cycle. They also assume that the serial-side inputs and tx_rd_data are settled at the frame edge. The stimulus therefore raises frame_stb for one cycle out of four and changes inputs only on falling edges. The handshake inputs are also assumed to come from a far end that follows the frame pattern. The directed tasks drive only such sequences, including the mismatch, abort and timeout paths. One task wires the outputs back to the inputs so that the block acts as its own peer.

// File: rtl/mon_hs_pkg.sv
package mon_hs_pkg;
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_CMP,
      RX_ACK,
      RX_FLAG,
      RX_ABT
   } rx_state_t;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_ARM,
      TX_HOLD,
      TX_FLAG,
      TX_END
   } tx_state_t;
endpackage

// File: rtl/mon_rx_side.sv
module mon_rx_side
   import mon_hs_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int RETRY_LIM = 8,
   localparam int CNT_W    = $clog2(RETRY_LIM + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_e_n,
   output logic              out_a_n,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_eom
);
   rx_state_t         st;
   logic [BYTE_W-1:0] cand;
   logic [CNT_W-1:0]  miss_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= RX_IDLE;
         cand     <= '0;
         miss_cnt <= '0;
         out_a_n  <= 1'b1;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         rx_eom   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         rx_eom   <= 1'b0;
         if (frame_stb) begin
            case (st)
               RX_IDLE: if (!in_e_n) begin
                  cand     <= in_byte;
                  miss_cnt <= '0;
                  st       <= RX_CMP;
               end
               RX_CMP: begin
                  if (in_e_n) begin
                     st <= RX_IDLE;
                  end else if (in_byte == cand) begin
                     rx_data  <= in_byte;
                     rx_valid <= 1'b1;
                     out_a_n  <= 1'b0;
                     st       <= RX_ACK;
                  end else if (miss_cnt == CNT_W'(RETRY_LIM - 1)) begin
                     st <= RX_ABT;
                  end else begin
                     cand     <= in_byte;
                     miss_cnt <= miss_cnt + CNT_W'(1);
                  end
               end
               RX_ACK: if (in_e_n) begin
                  out_a_n <= 1'b1;
                  cand    <= in_byte;
                  st      <= RX_FLAG;
               end
               RX_FLAG: begin
                  if (in_e_n) begin
                     rx_eom <= 1'b1;
                     st     <= RX_IDLE;
                  end else if (in_byte == cand) begin
                     rx_data  <= in_byte;
                     rx_valid <= 1'b1;
                     out_a_n  <= 1'b0;
                     st       <= RX_ACK;
                  end else begin
                     st <= RX_ABT;
                  end
               end
               RX_ABT: if (in_e_n) st <= RX_IDLE;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R3: a validated byte is always accompanied by an active acknowledge
   p_valid_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> !out_a_n);

   // R7: end of message leaves A inactive and never coincides with data
   p_eom_a_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eom |-> (out_a_n && !rx_valid));

   // R5: while an abort is pending, A stays inactive
   p_abort_a_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_ABT) |-> out_a_n);
endmodule

// File: rtl/mon_tx_side.sv
module mon_tx_side
   import mon_hs_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int MSG_MAX   = 16,
   parameter int RETRY_LIM = 8,
   localparam int IDX_W    = $clog2(MSG_MAX),
   localparam int LEN_W    = $clog2(MSG_MAX + 1),
   localparam int CNT_W    = $clog2(RETRY_LIM + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              in_a_n,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_e_n,
   input  logic              tx_start,
   input  logic [LEN_W-1:0]  tx_len,
   output logic [IDX_W-1:0]  tx_rd_idx,
   input  logic [BYTE_W-1:0] tx_rd_data,
   output logic              tx_done,
   output logic              tx_fail
);
   tx_state_t        st;
   logic [IDX_W-1:0] idx;
   logic [LEN_W-1:0] len_q;
   logic [CNT_W-1:0] wait_cnt;
   logic             armed;
   logic             last_byte;
   logic             len_ok;

   assign len_ok    = (tx_len != '0) && (tx_len <= LEN_W'(MSG_MAX));
   assign last_byte = (LEN_W'(idx) + LEN_W'(1)) == len_q;
   assign tx_rd_idx = (st == TX_HOLD) ? idx + IDX_W'(1) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= TX_IDLE;
         idx      <= '0;
         len_q    <= '0;
         wait_cnt <= '0;
         armed    <= 1'b0;
         out_byte <= '0;
         out_e_n  <= 1'b1;
         tx_done  <= 1'b0;
         tx_fail  <= 1'b0;
      end else begin
         tx_done <= 1'b0;
         tx_fail <= 1'b0;
         case (st)
            TX_IDLE: if (tx_start && len_ok) begin
               len_q <= tx_len;
               st    <= TX_ARM;
            end
            TX_ARM: if (frame_stb && in_a_n) begin
               out_e_n  <= 1'b0;
               out_byte <= tx_rd_data;
               idx      <= '0;
               armed    <= 1'b0;
               wait_cnt <= '0;
               st       <= TX_HOLD;
            end
            TX_HOLD: if (frame_stb) begin
               if (!in_a_n && armed) begin
                  armed    <= 1'b0;
                  wait_cnt <= '0;
                  out_e_n  <= 1'b1;
                  if (last_byte) begin
                     st <= TX_END;
                  end else begin
                     out_byte <= tx_rd_data;
                     idx      <= idx + IDX_W'(1);
                     st       <= TX_FLAG;
                  end
               end else if (wait_cnt == CNT_W'(RETRY_LIM - 1)) begin
                  out_e_n <= 1'b1;
                  tx_fail <= 1'b1;
                  st      <= TX_IDLE;
               end else if (in_a_n && armed && (idx != '0)) begin
                  out_e_n <= 1'b1;
                  st      <= TX_ARM;
               end else begin
                  wait_cnt <= wait_cnt + CNT_W'(1);
                  if (in_a_n) armed <= 1'b1;
               end
            end
            TX_FLAG: if (frame_stb) begin
               out_e_n <= 1'b0;
               st      <= TX_HOLD;
            end
            TX_END: if (frame_stb) begin
               tx_done <= 1'b1;
               st      <= TX_IDLE;
            end
            default: st <= TX_IDLE;
         endcase
      end
   end

   // R8: no message starts while the far receiver still holds A active
   p_start_needs_a_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_ARM && frame_stb && !in_a_n) |=> out_e_n);

   // R9: the flag for a following byte lasts exactly one frame
   p_flag_one_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == TX_FLAG && frame_stb) |=> !out_e_n);

   // R9: completion is reported with E inactive
   p_done_e_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> out_e_n);

   // R11: giving up releases E
   p_fail_e_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_fail |-> (out_e_n && !tx_done));
endmodule

// File: rtl/mon_handshake.sv
module mon_handshake #(
   parameter int BYTE_W    = 8,
   parameter int MSG_MAX   = 16,
   parameter int RETRY_LIM = 8,
   localparam int IDX_W    = $clog2(MSG_MAX),
   localparam int LEN_W    = $clog2(MSG_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_e_n,
   input  logic              in_a_n,
   output logic [BYTE_W-1:0] out_byte,
   output logic              out_e_n,
   output logic              out_a_n,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              rx_eom,
   input  logic              tx_start,
   input  logic [LEN_W-1:0]  tx_len,
   output logic [IDX_W-1:0]  tx_rd_idx,
   input  logic [BYTE_W-1:0] tx_rd_data,
   output logic              tx_done,
   output logic              tx_fail
);
   if (RETRY_LIM < 2) begin : g_bad_retry
      $error("RETRY_LIM must be at least 2");
   end
   if (MSG_MAX < 2) begin : g_bad_len
      $error("MSG_MAX must be at least 2");
   end

   mon_rx_side #(.BYTE_W(BYTE_W), .RETRY_LIM(RETRY_LIM)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .frame_stb(frame_stb),
      .in_byte  (in_byte),
      .in_e_n   (in_e_n),
      .out_a_n  (out_a_n),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .rx_eom   (rx_eom)
   );

   mon_tx_side #(.BYTE_W(BYTE_W), .MSG_MAX(MSG_MAX), .RETRY_LIM(RETRY_LIM)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_stb (frame_stb),
      .in_a_n    (in_a_n),
      .out_byte  (out_byte),
      .out_e_n   (out_e_n),
      .tx_start  (tx_start),
      .tx_len    (tx_len),
      .tx_rd_idx (tx_rd_idx),
      .tx_rd_data(tx_rd_data),
      .tx_done   (tx_done),
      .tx_fail   (tx_fail)
   );

   // R2: handshake bits and the outgoing byte move only on frame edges
   p_quiet_between_frames_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> ($stable(out_e_n) && $stable(out_a_n) && $stable(out_byte)));
endmodule

// File: tb/mon_handshake_tb.sv
module mon_handshake_tb_top;
   localparam int MSG_MAX = 16;
   localparam int LEN_W   = $clog2(MSG_MAX + 1);
   localparam int IDX_W   = $clog2(MSG_MAX);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_stb = 1'b0;
   logic loop_en = 1'b0;
   logic [7:0] drv_byte = 8'h00;
   logic drv_e_n = 1'b1;
   logic drv_a_n = 1'b1;
   logic [7:0] in_byte;
   logic in_e_n, in_a_n;
   logic [7:0] out_byte, rx_data;
   logic out_e_n, out_a_n, rx_valid, rx_eom, tx_done, tx_fail;
   logic tx_start = 1'b0;
   logic [LEN_W-1:0] tx_len = '0;
   logic [IDX_W-1:0] tx_rd_idx;
   logic [7:0] tx_rd_data;
   logic [7:0] mem [MSG_MAX];

   int checks = 0;
   int errors = 0;

   logic [7:0] c_byte, c_rx;
   logic c_e, c_a, c_valid, c_eom, c_done, c_fail;

   always #5 clk = ~clk;

   assign in_byte    = loop_en ? out_byte : drv_byte;
   assign in_e_n     = loop_en ? out_e_n  : drv_e_n;
   assign in_a_n     = loop_en ? out_a_n  : drv_a_n;
   assign tx_rd_data = mem[tx_rd_idx];

   mon_handshake dut_i (
      .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
      .in_byte(in_byte), .in_e_n(in_e_n), .in_a_n(in_a_n),
      .out_byte(out_byte), .out_e_n(out_e_n), .out_a_n(out_a_n),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_eom(rx_eom),
      .tx_start(tx_start), .tx_len(tx_len), .tx_rd_idx(tx_rd_idx),
      .tx_rd_data(tx_rd_data), .tx_done(tx_done), .tx_fail(tx_fail)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one frame: drive inputs, pulse frame_stb, capture, then check quiet gap
   task automatic tick(input logic e_n, input logic [7:0] b, input logic a_n);
      @(negedge clk);
      drv_e_n = e_n; drv_byte = b; drv_a_n = a_n;
      frame_stb = 1'b1;
      @(negedge clk);
      frame_stb = 1'b0;
      c_byte = out_byte; c_e = out_e_n; c_a = out_a_n; c_rx = rx_data;
      c_valid = rx_valid; c_eom = rx_eom; c_done = tx_done; c_fail = tx_fail;
      @(negedge clk);
      @(negedge clk);
      chk(out_e_n == c_e && out_a_n == c_a && out_byte == c_byte && !rx_valid
          && !rx_eom && !tx_done && !tx_fail, "R2 quiet between frames",
          {out_e_n, out_a_n}, {c_e, c_a});
   endtask

   task automatic start_msg(input int len);
      @(negedge clk);
      tx_start = 1'b1; tx_len = LEN_W'(len);
      @(negedge clk);
      tx_start = 1'b0;
   endtask

   task automatic t_reset;
      chk(out_e_n && out_a_n && out_byte == 8'h00 && !rx_valid && !rx_eom
          && !tx_done && !tx_fail, "R1 reset state",
          {out_e_n, out_a_n, rx_valid, tx_done}, 4'b1100);
   endtask

   task automatic t_rx_basic;
      tick(0, 8'hA5, 1);
      chk(!c_valid && c_a, "R3 first copy only", {c_valid, c_a}, 2'b01);
      tick(0, 8'hA5, 1);
      chk(c_valid && c_rx == 8'hA5 && !c_a, "R3 second copy accepted", c_rx, 8'hA5);
      tick(0, 8'hA5, 1);
      chk(!c_valid && !c_a, "R3 ack held", {c_valid, c_a}, 2'b00);
      tick(1, 8'h3C, 1);
      chk(!c_valid && c_a, "R4 flag frame A inactive", {c_valid, c_a}, 2'b01);
      tick(0, 8'h3C, 1);
      chk(c_valid && c_rx == 8'h3C && !c_a, "R4 following byte acked", c_rx, 8'h3C);
      tick(1, 8'h3C, 1);
      chk(!c_eom && c_a, "R7 one idle frame is not end", {c_eom, c_a}, 2'b01);
      tick(1, 8'h3C, 1);
      chk(c_eom && c_a, "R7 end of message pulse", {c_eom, c_a}, 2'b11);
   endtask

   task automatic t_rx_mismatch;
      tick(0, 8'h11, 1);
      tick(0, 8'h11, 1);
      tick(1, 8'h22, 1);
      tick(0, 8'h23, 1);
      chk(!c_valid && c_a, "R5 differing copy not accepted", {c_valid, c_a}, 2'b01);
      tick(0, 8'h23, 1);
      chk(!c_valid && c_a, "R5 abort keeps A inactive", {c_valid, c_a}, 2'b01);
      tick(1, 8'h00, 1);
      chk(!c_eom && c_a, "R5 abort released by idle E", {c_eom, c_a}, 2'b01);
      tick(0, 8'h44, 1);
      tick(0, 8'h44, 1);
      chk(c_valid && c_rx == 8'h44, "R5 recovery after abort", c_rx, 8'h44);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 1);
   endtask

   task automatic t_rx_retry;
      tick(0, 8'h00, 1);
      for (int i = 1; i <= 7; i++) tick(0, 8'(i), 1);
      tick(0, 8'h07, 1);
      chk(c_valid && c_rx == 8'h07 && !c_a, "R6 match within retry limit", c_rx, 8'h07);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 1);
      tick(0, 8'h10, 1);
      for (int i = 1; i <= 8; i++) tick(0, 8'(8'h10 + i), 1);
      tick(0, 8'h18, 1);
      chk(!c_valid && c_a, "R6 abort after retry limit", {c_valid, c_a}, 2'b01);
      tick(0, 8'h18, 1);
      chk(!c_valid && c_a, "R6 aborted stays silent", {c_valid, c_a}, 2'b01);
      tick(1, 8'h00, 1);
   endtask

   task automatic t_tx_handshake;
      drv_a_n = 1'b0;
      start_msg(2);
      tick(1, 8'h00, 0);
      chk(c_e, "R8 start waits for A inactive", c_e, 1);
      tick(1, 8'h00, 1);
      chk(!c_e && c_byte == mem[0], "R8 first byte with E active", c_byte, mem[0]);
      tick(1, 8'h00, 1);
      chk(!c_e && c_byte == mem[0], "R9 byte held until ack", c_byte, mem[0]);
      tick(1, 8'h00, 0);
      chk(c_e && c_byte == mem[1], "R9 flag frame with next byte", c_byte, mem[1]);
      tick(1, 8'h00, 0);
      chk(!c_e && c_byte == mem[1], "R9 flag lasts one frame", c_e, 0);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 1);
      chk(c_e, "R10 abort releases E", c_e, 1);
      tick(1, 8'h00, 1);
      chk(!c_e && c_byte == mem[0], "R10 restart from first byte", c_byte, mem[0]);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 0);
      tick(1, 8'h00, 0);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 0);
      chk(c_e && !c_done, "R9 E inactive after last byte", {c_e, c_done}, 2'b10);
      tick(1, 8'h00, 1);
      chk(c_e && c_done, "R9 done pulse", {c_e, c_done}, 2'b11);
   endtask

   task automatic t_tx_timeout;
      start_msg(1);
      tick(1, 8'h00, 1);
      chk(!c_e, "R11 byte placed", c_e, 0);
      start_msg(3);
      for (int i = 0; i < 7; i++) tick(1, 8'h00, 1);
      chk(!c_e && !c_fail, "R11 still waiting before limit", {c_e, c_fail}, 2'b00);
      tick(1, 8'h00, 1);
      chk(c_e && c_fail, "R11 give up at limit", {c_e, c_fail}, 2'b11);
      tick(1, 8'h00, 1);
      chk(c_e, "R12 start while busy ignored", c_e, 1);
   endtask

   task automatic t_bad_len;
      start_msg(0);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 1);
      chk(c_e, "R12 zero length ignored", c_e, 1);
      start_msg(MSG_MAX + 1);
      tick(1, 8'h00, 1);
      tick(1, 8'h00, 1);
      chk(c_e, "R12 oversize length ignored", c_e, 1);
   endtask

   task automatic t_loopback;
      logic [7:0] got [4];
      int n_got = 0;
      int flags = 0;
      int run = 0;
      bit done_seen = 0;
      bit eom_seen = 0;
      loop_en = 1'b1;
      start_msg(4);
      for (int i = 0; i < 40; i++) begin
         tick(1, 8'h00, 1);
         if (c_valid && n_got < 4) begin got[n_got] = c_rx; n_got++; end
         if (c_done) done_seen = 1;
         if (c_eom) eom_seen = 1;
         if (!done_seen) begin
            if (c_e) run++;
            else begin
               if (run == 1) flags++;
               run = 0;
            end
         end
      end
      chk(n_got == 4, "R3 loopback byte count", n_got, 4);
      for (int i = 0; i < 4; i++)
         chk(got[i] == mem[i], "R4 loopback byte value", got[i], mem[i]);
      chk(flags == 3, "R9 single-frame flags", flags, 3);
      chk(done_seen && eom_seen, "R7 loopback end seen", {done_seen, eom_seen}, 2'b11);
      loop_en = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < MSG_MAX; i++) mem[i] = 8'(8'h81 + 8'h13 * i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_basic();
      t_rx_mismatch();
      t_rx_retry();
      t_tx_handshake();
      t_tx_timeout();
      t_bad_len();
      t_loopback();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule